// File: doc/BRIEF.md
# Sized Flag-Setting Integer ALU

This block is a 64-bit integer execution unit that runs one arithmetic or logic operation per cycle at a chosen operand size of 1, 2, 4 or 8 bytes. The first operand sits in the destination position and also acts as the first source. The second operand is the plain source. The result and its write-enable come out combinationally in the same cycle as the request. Four condition flags (carry, zero, sign, overflow) are computed at the selected width. They are captured into a register on the rising clock edge at which a valid, legal operation is presented.

The unit has no back-pressure. It accepts a request on every cycle in which `in_valid` is high, so there is no ready signal, and a request is never stalled or dropped. A register file around the block writes `res_data` into the destination register when `res_we` is high. Compare and test only shape the flags: they never raise `res_we`. Flags read by a branch unit are valid from the edge after the operation that produced them, and they persist until the next valid, legal operation.

Top module: `alu_sized_flags`

## Requirements
- R1: `in_size` selects the operand width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Only the low bits of each operand at that width take part, and `res_data` is zero above the selected width.
- R2: Opcode 0 (add) yields dst + src at the selected width with `res_we` = 1.
- R3: Opcode 1 (subtract) yields dst − src at the selected width with `res_we` = 1.
- R4: Opcode 2 (compare) evaluates dst − src and keeps `res_we` = 0. Afterwards carry = 1 exactly when dst < src unsigned, and zero = 1 exactly when dst equals src, both at the selected width.
- R5: Opcode 3 (test) evaluates dst AND src and keeps `res_we` = 0. Zero is set when the AND is all-zero at the selected width, and sign takes its top bit at that width.
- R6: Opcode 4 (AND) and opcode 5 (XOR) write dst AND src and dst XOR src. Opcode 6 (invert) writes the bit inverse of dst and ignores src. All three raise `res_we`.
- R7: For every legal operation, sign equals the result bit at position width−1, and zero is 1 exactly when the width-limited result is zero.
- R8: On add, carry is the carry out of the selected width. Overflow is set when both operands share a sign and the result sign differs. On subtract and compare, carry is the borrow, and overflow is set when the operand signs differ and the result sign differs from dst.
- R9: Test, AND, XOR and invert clear carry and overflow.
- R10: Flags update on the rising edge where `in_valid` = 1 with a legal opcode. They hold on cycles without `in_valid` and on opcode 7 (reserved), which also keeps `res_we` = 0.
- R11: An active-low `rst_n` clears all four flags to 0 asynchronously.
- R12: `res_we` is 0 whenever `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 compare, 3 test, 4 and, 5 xor, 6 invert, 7 reserved) |
| in_size | input | 2 | Operand width code (0..3 = 1, 2, 4, 8 bytes) |
| in_dst | input | 64 | Destination operand, also first source |
| in_src | input | 64 | Second source operand |
| res_data | output | 64 | Width-limited, zero-extended result |
| res_we | output | 1 | Result write-enable for the destination |
| flag_c | output | 1 | Registered carry / borrow flag |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_o | output | 1 | Registered signed-overflow flag |

## Verification
The result datapath is combinational, so a wrong lane select or a bad width mask shows up in `res_data` in the same cycle as the request. A wrong opcode decode shows on `res_we` in that same cycle. The flag register is the only state, and a bad next-flag value or update enable is visible on the flag pins one edge after the operation. A spurious update or a missed update leaves a stale or corrupted flag on the pins until the next legal valid operation. The bench therefore checks the flags on the edge after every vector and again across idle and reserved-opcode cycles.

// File: rtl/alu_sz_pkg.sv
package alu_sz_pkg;

  localparam int XLEN    = 64;
  localparam int NSZ     = $clog2(XLEN / 8) + 1;
  localparam int SZW     = $clog2(NSZ);
  localparam int OPW     = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_TEST = 3'd3,
    OP_AND  = 3'd4,
    OP_XOR  = 3'd5,
    OP_NOT  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
  } flags_t;

endpackage

// File: rtl/alu_width_mask.sv
module alu_width_mask
  import alu_sz_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int NS  = NSZ,
  localparam int SW = $clog2(NS)
) (
  input  logic [SW-1:0] size,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  top_bit
);

  // width in bits for the current size code: 8 << size
  always_comb begin
    for (int j = 0; j < W; j++) begin
      mask[j]    = (j < (8 << int'(size)));
      top_bit[j] = (j == ((8 << int'(size)) - 1));
    end
  end

endmodule

// File: rtl/alu_lane.sv
module alu_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          is_sub,
  output logic [LW-1:0] sum,
  output logic          carry,
  output logic          ovf
);

  logic [LW:0] ext;
  logic        a_s, b_s, r_s;

  always_comb begin
    if (is_sub) ext = {1'b0, a} - {1'b0, b};
    else        ext = {1'b0, a} + {1'b0, b};
  end

  assign sum   = ext[LW-1:0];
  assign carry = ext[LW];         // carry out on add, borrow on subtract
  assign a_s   = a[LW-1];
  assign b_s   = b[LW-1];
  assign r_s   = ext[LW-1];

  always_comb begin
    if (is_sub) ovf = (a_s != b_s) && (r_s != a_s);
    else        ovf = (a_s == b_s) && (r_s != a_s);
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_sz_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int NS  = NSZ,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  op_e           op,
  input  logic [SW-1:0] size,
  input  logic [W-1:0]  dst,
  input  logic [W-1:0]  src,
  output logic [W-1:0]  res,
  output logic          wr,
  output logic          upd,
  output flags_t        nxt
);

  logic [W-1:0] mask, top_bit;
  logic [W-1:0] lane_sum [NS];
  logic         lane_c   [NS];
  logic         lane_o   [NS];
  logic         is_sub, is_arith, legal;
  logic [W-1:0] raw;

  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign legal    = (op != OP_RSV);

  alu_width_mask #(.W(W), .NS(NS)) u_mask (
    .size    (size),
    .mask    (mask),
    .top_bit (top_bit)
  );

  for (genvar i = 0; i < NS; i++) begin : g_lane
    localparam int LW = 8 << i;
    logic [LW-1:0] s;
    alu_lane #(.LW(LW)) u_lane (
      .a      (dst[LW-1:0]),
      .b      (src[LW-1:0]),
      .is_sub (is_sub),
      .sum    (s),
      .carry  (lane_c[i]),
      .ovf    (lane_o[i])
    );
    if (LW < W) begin : g_ext
      assign lane_sum[i] = {{(W-LW){1'b0}}, s};
    end else begin : g_full
      assign lane_sum[i] = s;
    end
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: raw = lane_sum[size];
      OP_TEST, OP_AND:        raw = dst & src;
      OP_XOR:                 raw = dst ^ src;
      OP_NOT:                 raw = ~dst;
      default:                raw = '0;
    endcase
  end

  assign res = raw & mask;

  always_comb begin
    nxt.z = (res == '0);
    nxt.s = |(res & top_bit);
    nxt.c = is_arith ? lane_c[size] : 1'b0;
    nxt.o = is_arith ? lane_o[size] : 1'b0;
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_NOT: wr = valid;
      default:                                wr = 1'b0;
    endcase
  end

  assign upd = valid && legal;

  p_cmp_test_no_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == OP_CMP || op == OP_TEST) |-> !wr);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (size != SW'(NS-1)) |-> (res[W-1:W/2] == '0));

  p_borrow_ltu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_sub |-> (nxt.c == ((dst & mask) < (src & mask))));

  p_wr_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !wr);

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_sz_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nxt,
  output flags_t flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= nxt;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags == $past(nxt)));

endmodule

// File: rtl/alu_sized_flags.sv
module alu_sized_flags
  import alu_sz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPW-1:0]    in_op,
  input  logic [SZW-1:0]    in_size,
  input  logic [XLEN-1:0]   in_dst,
  input  logic [XLEN-1:0]   in_src,
  output logic [XLEN-1:0]   res_data,
  output logic              res_we,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o
);

  op_e    op;
  logic   upd;
  flags_t nxt, flags;

  assign op = op_e'(in_op);

  alu_exec #(.W(XLEN), .NS(NSZ)) u_exec (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (in_valid),
    .op    (op),
    .size  (in_size),
    .dst   (in_dst),
    .src   (in_src),
    .res   (res_data),
    .wr    (res_we),
    .upd   (upd),
    .nxt   (nxt)
  );

  alu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .nxt   (nxt),
    .flags (flags)
  );

  assign flag_c = flags.c;
  assign flag_z = flags.z;
  assign flag_s = flags.s;
  assign flag_o = flags.o;

  p_logic_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_TEST || op == OP_AND || op == OP_XOR || op == OP_NOT)
    |=> (!flag_c && !flag_o));

  p_zf_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (flag_z == ($past(res_data) == '0)));

endmodule

// File: tb/alu_sized_flags_tb_top.sv
module alu_sized_flags_tb_top;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        we;
    logic [3:0]  fl;   // {c, z, s, o}
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd3, 64'h1,                   64'h2,                   64'h3,                   1'b1, 4'b0000},
    '{3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF7F, 64'h1,                   64'h80,                  1'b1, 4'b0011}, // R1 upper junk
    '{3'd0, 2'd0, 64'hFF,                  64'h1,                   64'h0,                   1'b1, 4'b1100},
    '{3'd1, 2'd1, 64'h0,                   64'h1,                   64'hFFFF,                1'b1, 4'b1010},
    '{3'd1, 2'd2, 64'h8000_0000,           64'h1,                   64'h7FFF_FFFF,           1'b1, 4'b0001},
    '{3'd2, 2'd3, 64'h5,                   64'h5,                   64'h0,                   1'b0, 4'b0100},
    '{3'd2, 2'd0, 64'h1,                   64'h2,                   64'hFF,                  1'b0, 4'b1010},
    '{3'd2, 2'd2, 64'h7FFF_FFFF,           64'hFFFF_FFFF,           64'h8000_0000,           1'b0, 4'b1011},
    '{3'd3, 2'd1, 64'hF0F0,                64'h0F0F,                64'h0,                   1'b0, 4'b0100},
    '{3'd3, 2'd0, 64'h80,                  64'hFF,                  64'h80,                  1'b0, 4'b0010},
    '{3'd5, 2'd2, 64'hDEAD_BEEF_1234_5678, 64'hDEAD_BEEF_1234_5678, 64'h0,                   1'b1, 4'b0100},
    '{3'd4, 2'd3, 64'h8000_0000_0000_00FF, 64'hF000_0000_0000_000F, 64'h8000_0000_0000_000F, 1'b1, 4'b0010},
    '{3'd6, 2'd1, 64'hFF,                  64'h1234,                64'hFF00,                1'b1, 4'b0010},
    '{3'd6, 2'd3, 64'h0,                   64'h5555,                64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'b0010},
    '{3'd0, 2'd2, 64'hFFFF_FFFF_8000_0000, 64'h8000_0000,           64'h0,                   1'b1, 4'b1101},
    '{3'd0, 2'd1, 64'h7FFF,                64'h7FFF,                64'hFFFE,                1'b1, 4'b0011}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [1:0]  in_size;
  logic [63:0] in_dst, in_src;
  logic [63:0] res_data;
  logic        res_we, flag_c, flag_z, flag_s, flag_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  alu_sized_flags dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_size  (in_size),
    .in_dst   (in_dst),
    .in_src   (in_src),
    .res_data (res_data),
    .res_we   (res_we),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .flag_o   (flag_o)
  );

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fl_now();
    return {60'd0, flag_c, flag_z, flag_s, flag_o};
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0;
    in_dst = '0;  in_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset flags", fl_now(), 64'h0);
    rst_n = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = VECS[i].op;
      in_size  = VECS[i].sz;
      in_dst   = VECS[i].a;
      in_src   = VECS[i].b;
      #1;
      chk({op_tag(VECS[i].op), " R1 result"}, res_data, VECS[i].res);
      chk({op_tag(VECS[i].op), " write enable"}, {63'd0, res_we}, {63'd0, VECS[i].we});
      @(negedge clk);
      chk({op_tag(VECS[i].op), " R7 R8 R9 flags"}, fl_now(), {60'd0, VECS[i].fl});
    end

    // R12 / R10: idle cycle with operands that would change flags
    in_valid = 1'b0; in_op = 3'd0; in_size = 2'd3; in_dst = '0; in_src = '0;
    #1;
    chk("R12 no write without valid", {63'd0, res_we}, 64'h0);
    @(negedge clk);
    chk("R10 flags hold when idle", fl_now(), 64'h3);

    // R10: reserved opcode
    in_valid = 1'b1; in_op = 3'd7; in_size = 2'd0; in_dst = 64'h0; in_src = 64'h0;
    #1;
    chk("R10 reserved no write", {63'd0, res_we}, 64'h0);
    @(negedge clk);
    chk("R10 reserved flags hold", fl_now(), 64'h3);

    // R4: compare at byte width again after idle, then mid-run reset
    in_op = 3'd2; in_size = 2'd0; in_dst = 64'hAB01; in_src = 64'h0002;
    @(negedge clk);
    chk("R4 compare ignores upper bits", fl_now(), 64'hA);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset mid-run", fl_now(), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule